// File: doc/BRIEF.md
# Signed-Amount Dynamic Barrel Shifter

This block shifts a data word by an amount and direction taken from a second word of the same width. The sign bit of the control word sets the direction. When it is clear, the data moves left. When it is set, the data moves right by the two's-complement magnitude of the control's low bits. A mode input selects whether a right shift fills with copies of the sign bit (arithmetic) or with zeros (logical).

A negative control whose low bits are all zero asks for a right shift by the full word width. A normal log-stage shifter cannot express that amount, so the block handles it as a separate case. The datapath is combinational. A parameter can add one register stage on the result, and an execution pipeline uses that stage to meet timing. The block has no flag outputs, so no status bit is touched.

Top module: `dshift_unit`

## Requirements
- R1: With control bit DATA_W-1 clear, the result is the data shifted left by the control's low log2(DATA_W) bits (the shift field), with zeros entering from bit 0.
- R2: With control bit DATA_W-1 set and a nonzero shift field f, the result is the data shifted right by DATA_W - f positions, which equals (~f)+1 taken in the field width.
- R3: The mode input arith_i selects the fill for right shifts: 1 is arithmetic and copies data bit DATA_W-1 into the vacated bits, 0 is logical and fills with zeros. The mode has no effect on left shifts.
- R4: With control bit DATA_W-1 set and a zero shift field in arithmetic mode, the result is all ones when data bit DATA_W-1 is set and all zeros otherwise.
- R5: With control bit DATA_W-1 set and a zero shift field in logical mode, the result is zero for any data.
- R6: Control bits between the shift field and the sign bit have no effect on the result.
- R7: A control of zero returns the data unchanged in both modes.
- R8: With OUT_REG=1, result_o shows the result for the inputs sampled at the previous rising clk_i edge, and it is zero while rst_ni is low. With OUT_REG=0, result_o follows the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | DATA_W | Operand to be shifted |
| ctrl_i | input | DATA_W | Signed shift control: sign gives direction, low bits give amount |
| arith_i | input | 1 | 1 = arithmetic right shift, 0 = logical |
| result_o | output | DATA_W | Shifted result |

## Verification
The bench builds two copies at DATA_W=32: one with OUT_REG=0 and one with OUT_REG=1. It compares both against the same expectations, so the combinational path and the one-cycle registered timing are both checked against the same vectors.

The 32-bit width brings several boundaries within reach of a short table:
- a control of 0xFFFFFFFF, the one-position right shift;
- a shift field of 1, the widest non-full right shift;
- the full-width case with negative and positive data;
- control words with stray middle bits set.

A stream of pseudo-random operands then covers the remaining amounts and mixes of the sign bits.

// File: rtl/dshift_pkg.sv
package dshift_pkg;

  typedef enum logic {
    MODE_LOGICAL = 1'b0,
    MODE_ARITH   = 1'b1
  } shift_mode_e;

  typedef enum logic [1:0] {
    DIR_LEFT  = 2'd0,
    DIR_RIGHT = 2'd1,
    DIR_FULL  = 2'd2
  } shift_dir_e;

endpackage

// File: rtl/dshift_decode.sv
module dshift_decode
  import dshift_pkg::*;
#(
  parameter int unsigned SHAMT_W = 5
) (
  input  logic               sign_i,
  input  logic [SHAMT_W-1:0] field_i,
  output shift_dir_e         dir_o,
  output logic [SHAMT_W-1:0] amt_o
);

  logic [SHAMT_W-1:0] neg_amt;

  // wraps to zero exactly when field is zero; that case goes to DIR_FULL
  assign neg_amt = (~field_i) + {{(SHAMT_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (!sign_i) begin
      dir_o = DIR_LEFT;
      amt_o = field_i;
    end else if (field_i == '0) begin
      dir_o = DIR_FULL;
      amt_o = '0;
    end else begin
      dir_o = DIR_RIGHT;
      amt_o = neg_amt;
    end
  end

endmodule

// File: rtl/dshift_barrel.sv
module dshift_barrel
  import dshift_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  shift_dir_e         dir_i,
  input  logic               fill_i,
  output logic [DATA_W-1:0]  result_o
);

  logic [DATA_W-1:0] stage [0:SHAMT_W];
  logic              go_right;

  assign go_right = (dir_i == DIR_RIGHT);
  assign stage[0] = data_i;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    logic [DATA_W-1:0] shl, shr;
    assign shl = {stage[k][DATA_W-1-S:0], {S{1'b0}}};
    assign shr = {{S{fill_i}}, stage[k][DATA_W-1:S]};
    assign stage[k+1] = !amt_i[k] ? stage[k] : (go_right ? shr : shl);
  end

  assign result_o = (dir_i == DIR_FULL) ? {DATA_W{fill_i}} : stage[SHAMT_W];

endmodule

// File: rtl/dshift_unit.sv
module dshift_unit
  import dshift_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] result_o
);

  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  shift_dir_e         dir;
  logic [SHAMT_W-1:0] amt;
  logic               fill;
  logic [DATA_W-1:0]  shift_res;
  shift_mode_e        mode;

  assign mode = shift_mode_e'(arith_i);

  dshift_decode #(.SHAMT_W(SHAMT_W)) u_decode (
    .sign_i  (ctrl_i[DATA_W-1]),
    .field_i (ctrl_i[SHAMT_W-1:0]),
    .dir_o   (dir),
    .amt_o   (amt)
  );

  assign fill = (mode == MODE_ARITH) && (dir != DIR_LEFT) && data_i[DATA_W-1];

  dshift_barrel #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_barrel (
    .data_i   (data_i),
    .amt_i    (amt),
    .dir_i    (dir),
    .fill_i   (fill),
    .result_o (shift_res)
  );

  if (OUT_REG) begin : g_reg
    logic [DATA_W-1:0] res_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q <= '0;
      else         res_q <= shift_res;
    end
    assign result_o = res_q;

    assert_reg_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> result_o == $past(shift_res));
  end else begin : g_comb
    assign result_o = shift_res;
  end

  // checks on datapath output versus ports
  assert_zero_ctrl_passthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i == '0) |-> (shift_res == data_i));

  assert_full_logical_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[DATA_W-1] && ctrl_i[SHAMT_W-1:0] == '0 && !arith_i) |-> (shift_res == '0));

  assert_full_arith_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[DATA_W-1] && ctrl_i[SHAMT_W-1:0] == '0 && arith_i)
      |-> (shift_res == {DATA_W{data_i[DATA_W-1]}}));

  assert_left_lsb_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[DATA_W-1] && ctrl_i[SHAMT_W-1:0] != '0) |-> (shift_res[0] == 1'b0));

  assert_right_fill_msb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[DATA_W-1] && ctrl_i[SHAMT_W-1:0] != '0)
      |-> (shift_res[DATA_W-1] == (arith_i & data_i[DATA_W-1])));

endmodule

// File: tb/dshift_unit_test.sv
module dshift_unit_test;

  localparam int W = 32;
  localparam int NVEC = 15;

  // {arith, data, ctrl, expected}
  localparam logic [96:0] VEC [NVEC] = '{
    {1'b0, 32'h12345678, 32'h00000000, 32'h12345678}, // R7
    {1'b0, 32'h00000001, 32'h00000004, 32'h00000010}, // R1
    {1'b1, 32'h80000001, 32'h0000001F, 32'h80000000}, // R1 R3
    {1'b1, 32'h80000000, 32'hFFFFFFFF, 32'hC0000000}, // R2 R3
    {1'b0, 32'h80000000, 32'hFFFFFFFF, 32'h40000000}, // R2 R3
    {1'b1, 32'hF0000000, 32'hFFFFFFFC, 32'hFF000000}, // R2 R3
    {1'b0, 32'hF0000000, 32'hFFFFFFFC, 32'h0F000000}, // R2 R3
    {1'b1, 32'h80000000, 32'hFFFFFFE1, 32'hFFFFFFFF}, // R2 shift 31
    {1'b0, 32'h80000000, 32'hFFFFFFE1, 32'h00000001}, // R2 shift 31
    {1'b1, 32'h80000000, 32'h80000000, 32'hFFFFFFFF}, // R4
    {1'b1, 32'h7FFFFFFF, 32'hFFFFFFE0, 32'h00000000}, // R4
    {1'b0, 32'hFFFFFFFF, 32'h80000000, 32'h00000000}, // R5
    {1'b0, 32'h0000000F, 32'h7FFFFFE2, 32'h0000003C}, // R6
    {1'b1, 32'h000000F0, 32'h8000001C, 32'h0000000F}, // R6
    {1'b0, 32'hA5A5A5A5, 32'h00000020, 32'hA5A5A5A5}  // R6 R7
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  data = '0, ctrl = '0;
  logic          arith = 1'b0;
  logic [W-1:0]  res_comb, res_reg;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  dshift_unit #(.DATA_W(W), .OUT_REG(1'b0)) uut_comb (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .ctrl_i(ctrl),
    .arith_i(arith), .result_o(res_comb));

  dshift_unit #(.DATA_W(W), .OUT_REG(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .ctrl_i(ctrl),
    .arith_i(arith), .result_o(res_reg));

  function automatic logic [W-1:0] ref_shift(logic a, logic [W-1:0] d, logic [W-1:0] c);
    int n;
    if (!c[W-1]) return d << c[4:0];
    if (c[4:0] == 5'd0) return (a && d[W-1]) ? '1 : '0;
    n = 32 - int'(c[4:0]);
    if (a) return W'($signed(d) >>> n);
    return d >> n;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h (arith=%0b data=%08h ctrl=%08h)",
               req, act, exp, arith, data, ctrl);
    end
  endtask

  // drive at negedge, check comb now, registered copy after next posedge
  task automatic apply(string req, logic a, logic [W-1:0] d, logic [W-1:0] c, logic [W-1:0] exp);
    @(negedge clk);
    arith = a; data = d; ctrl = c;
    #1;
    check({req, " comb"}, res_comb, exp);
    @(posedge clk);
    #1;
    check({req, " reg R8"}, res_reg, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    data = 32'hDEADBEEF; ctrl = 32'h00000004;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset", res_reg, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply("table", VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // mode has no effect on a left shift (R3)
    apply("R3 left arith", 1'b1, 32'h80000003, 32'h00000001, 32'h00000006);
    // middle control bits ignored for the full-width case (R6)
    apply("R6 full", 1'b1, 32'h80000000, 32'hABCDEF00 | 32'h80000000, 32'hFFFFFFFF);

    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] d, c;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      d = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      c = lfsr;
      apply("R1 R2 R3 random", lfsr[7], d, c, ref_shift(lfsr[7], d, c));
    end

    // reset clears the register again (R8)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 reset again", res_reg, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule